// File: doc/BRIEF.md
# Half-Word Staged Register Access Bridge

This block sits between an external host bus and a device whose internal registers are 32 bits wide. It accepts asynchronous active-low chip-select, read and write strobes plus a 4-bit address, and decodes one access each time a strobe pair becomes active. Of the sixteen direct locations, three are stream-channel ports, one is reserved, three are special (a half-word staging register, an indirect address register and an indirect data register), and the rest are plain 16-bit control registers.

A host that is only 16 bits wide reaches 32-bit targets through the staging register. For a write, it first loads the upper half into the staging register; the following write of the lower half to the 32-bit target commits both halves at once. For a read, the upper half comes back at once, and the lower half is parked in the staging register so that a later read of it returns the lower half. A bit in the bus configuration register switches the host to full 32-bit width. In that mode, the upper half of 16-bit registers is dropped on writes and reads back as zero.

The indirect pair reaches a larger internal 32-bit space. A write to the indirect data location sends one write strobe on an internal bus to the address held in the indirect address register. A read sends one read strobe, and the internal bus answers one cycle later.

Top module: `halfword_reg_bridge`

## Requirements
- R1: After reset, the read data output is zero, no internal-bus or stream strobe is active, the staging register reads zero and the host width is 16 bits.
- R2: Addresses 0x04-0x09 and 0x0D-0x0F are 16-bit registers. A write keeps host data bits 15:0 only, and a read returns the stored value in bits 15:0 with bits 31:16 zero, in either host width.
- R3: With a 16-bit host, a write to a 32-bit target (0x0B indirect address, 0x0C indirect data) commits {staging register, host data bits 15:0}. Writing address 0x0A loads the staging register from host data bits 15:0.
- R4: With a 16-bit host, a read of a 32-bit target returns its bits 31:16 in read data bits 15:0, with bits 31:16 zero. Its bits 15:0 are stored in the staging register.
- R5: A read of the staging register (0x0A) returns its content in bits 15:0. If no 32-bit read came in between, this is the last value written to it.
- R6: A write to 0x0C produces exactly one single-cycle internal write strobe. It carries the indirect address register's value as the address and the committed 32-bit value as the data, and it never coincides with an internal read strobe.
- R7: A read of 0x0C produces exactly one single-cycle internal read strobe at the indirect address. The internal read data is sampled one cycle after the strobe and returned to the host (split per R4 for a 16-bit host).
- R8: Reserved address 0x03 reads as zero. A write to it changes no register and no staging content.
- R9: Stream addresses 0x00-0x02 never use or alter the staging register. Each access gives one stream strobe with the channel number (0-2) on the select output. Data is bits 15:0 zero-extended for a 16-bit host and all 32 bits for a 32-bit host, in both directions.
- R10: With a 32-bit host, the 32-bit targets are written and read at full width, and the staging register is neither used nor altered.
- R11: Bit 0 of the bus configuration register at 0x08 selects the host width: 1 means 32-bit, 0 means 16-bit. The new width applies from the next access.
- R12: A strobe held active for many cycles performs exactly one access. If read and write are active together, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Asynchronous chip select, active low |
| rdN | input | 1 | Asynchronous read strobe, active low |
| weN | input | 1 | Asynchronous write strobe, active low |
| hostAddr | input | 4 | Direct register address, stable while strobed |
| hostWdata | input | 32 | Host write data, stable while strobed |
| hostRdata | output | 32 | Registered host read data |
| ibAddr | output | 32 | Internal bus address |
| ibWdata | output | 32 | Internal bus write data |
| ibWe | output | 1 | Internal bus write strobe, one cycle |
| ibRe | output | 1 | Internal bus read strobe, one cycle |
| ibRdata | input | 32 | Internal bus read data, valid one cycle after ibRe |
| streamSel | output | 2 | Stream channel number of the last stream access |
| streamWdata | output | 32 | Stream write data |
| streamWe | output | 1 | Stream write strobe, one cycle |
| streamRe | output | 1 | Stream read (pop) strobe, one cycle |
| streamRdata | input | 32 | Head data of the selected stream |

## Verification
The bench drives the staging sequence with distinct upper and lower patterns, so that swapped or lost halves show up both on the internal write bus and in the parked lower half. The same accesses run in both host widths. This separates truncation and zero-filling of 16-bit registers from full-width passing of 32-bit targets and streams. Between staging steps, accesses to the reserved slot, the stream ports and 16-bit registers show whether any of them corrupts the staging content. A behavioural model predicts every read word and internal-bus transfer, and the read data is compared with it on every idle clock.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam int ADDR_W = 4;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int NUM_DIRECT = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_RESERVED = 4'h3;
  localparam logic [ADDR_W-1:0] A_BUSCFG   = 4'h8;
  localparam logic [ADDR_W-1:0] A_STAGE    = 4'hA;
  localparam logic [ADDR_W-1:0] A_IADDR    = 4'hB;
  localparam logic [ADDR_W-1:0] A_IDATA    = 4'hC;
  localparam int LAST_STREAM = 2;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic              selStream;
    logic              selReserved;
    logic              selStage;
    logic              selIaddr;
    logic              selIdata;
    logic              selGeneral;
  } accessStrobesT;

  function automatic logic isGeneralAddr(input int a);
    return !(a <= LAST_STREAM || a == int'(A_RESERVED) || a == int'(A_STAGE) ||
             a == int'(A_IADDR) || a == int'(A_IDATA));
  endfunction
endpackage

// File: rtl/hrb_ctrl.sv
module hrb_ctrl
  import hrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] hostAddr,
  output accessStrobesT     strobes
);
  logic [SYNC_STAGES-1:0] csSync, rdSync, weSync;
  logic wrLvl, rdLvl, wrPrev, rdPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSync[0] <= 1'b0;
      rdSync[0] <= 1'b0;
      weSync[0] <= 1'b0;
    end else begin
      csSync[0] <= ~csN;
      rdSync[0] <= ~rdN;
      weSync[0] <= ~weN;
    end
  end

  genvar s;
  generate
    for (s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          csSync[s] <= 1'b0;
          rdSync[s] <= 1'b0;
          weSync[s] <= 1'b0;
        end else begin
          csSync[s] <= csSync[s-1];
          rdSync[s] <= rdSync[s-1];
          weSync[s] <= weSync[s-1];
        end
      end
    end
  endgenerate

  assign wrLvl = csSync[SYNC_STAGES-1] & weSync[SYNC_STAGES-1];
  assign rdLvl = csSync[SYNC_STAGES-1] & rdSync[SYNC_STAGES-1] & ~wrLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrLvl;
      rdPrev <= rdLvl;
    end
  end

  always_comb begin
    strobes.wr          = wrLvl & ~wrPrev;
    strobes.rd          = rdLvl & ~rdPrev;
    strobes.addr        = hostAddr;
    strobes.selStream   = int'(hostAddr) <= LAST_STREAM;
    strobes.selReserved = hostAddr == A_RESERVED;
    strobes.selStage    = hostAddr == A_STAGE;
    strobes.selIaddr    = hostAddr == A_IADDR;
    strobes.selIdata    = hostAddr == A_IDATA;
    strobes.selGeneral  = isGeneralAddr(int'(hostAddr));
  end
endmodule

// File: rtl/hrb_datapath.sv
module hrb_datapath
  import hrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobesT     strobes,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic [WORD_W-1:0] ibAddr,
  output logic [WORD_W-1:0] ibWdata,
  output logic              ibWe,
  output logic              ibRe,
  input  logic [WORD_W-1:0] ibRdata,
  output logic [1:0]        streamSel,
  output logic [WORD_W-1:0] streamWdata,
  output logic              streamWe,
  output logic              streamRe,
  input  logic [WORD_W-1:0] streamRdata,
  output logic              modeWide
);
  logic [HALF_W-1:0] genRegs [NUM_DIRECT];
  logic [HALF_W-1:0] stage;
  logic [WORD_W-1:0] iaddr;
  logic              idataPend;
  logic [WORD_W-1:0] wideWord;

  genvar g;
  generate
    for (g = 0; g < NUM_DIRECT; g++) begin : g_regs
      if (isGeneralAddr(g)) begin : g_store
        always_ff @(posedge clk) begin
          if (!rstN) genRegs[g] <= '0;
          else if (strobes.wr && strobes.addr == ADDR_W'(g))
            genRegs[g] <= hostWdata[HALF_W-1:0];
        end
      end else begin : g_none
        assign genRegs[g] = '0;
      end
    end
  endgenerate

  assign modeWide = genRegs[A_BUSCFG][0];
  assign wideWord = modeWide ? hostWdata : {stage, hostWdata[HALF_W-1:0]};

  function automatic logic [WORD_W-1:0] narrowData(input logic wide, input logic [WORD_W-1:0] d);
    return wide ? d : {{HALF_W{1'b0}}, d[HALF_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] splitUpper(input logic wide, input logic [WORD_W-1:0] d);
    return wide ? d : {{HALF_W{1'b0}}, d[WORD_W-1:HALF_W]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata   <= '0;
      stage       <= '0;
      iaddr       <= '0;
      ibAddr      <= '0;
      ibWdata     <= '0;
      ibWe        <= 1'b0;
      ibRe        <= 1'b0;
      idataPend   <= 1'b0;
      streamSel   <= '0;
      streamWdata <= '0;
      streamWe    <= 1'b0;
      streamRe    <= 1'b0;
    end else begin
      ibWe      <= 1'b0;
      ibRe      <= 1'b0;
      streamWe  <= 1'b0;
      streamRe  <= 1'b0;
      idataPend <= ibRe;
      if (strobes.wr) begin
        if (strobes.selStage) stage <= hostWdata[HALF_W-1:0];
        if (strobes.selIaddr) iaddr <= wideWord;
        if (strobes.selIdata) begin
          ibWe    <= 1'b1;
          ibAddr  <= iaddr;
          ibWdata <= wideWord;
        end
        if (strobes.selStream) begin
          streamWe    <= 1'b1;
          streamSel   <= strobes.addr[1:0];
          streamWdata <= narrowData(modeWide, hostWdata);
        end
      end
      if (strobes.rd) begin
        if (strobes.selIdata) begin
          ibRe   <= 1'b1;
          ibAddr <= iaddr;
        end else if (strobes.selIaddr) begin
          hostRdata <= splitUpper(modeWide, iaddr);
          if (!modeWide) stage <= iaddr[HALF_W-1:0];
        end else if (strobes.selStage) begin
          hostRdata <= {{HALF_W{1'b0}}, stage};
        end else if (strobes.selStream) begin
          hostRdata <= narrowData(modeWide, streamRdata);
          streamRe  <= 1'b1;
          streamSel <= strobes.addr[1:0];
        end else if (strobes.selGeneral) begin
          hostRdata <= {{HALF_W{1'b0}}, genRegs[strobes.addr]};
        end else begin
          hostRdata <= '0;
        end
      end
      if (idataPend) begin
        hostRdata <= splitUpper(modeWide, ibRdata);
        if (!modeWide) stage <= ibRdata[HALF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/halfword_reg_bridge.sv
module halfword_reg_bridge
  import hrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic [WORD_W-1:0] ibAddr,
  output logic [WORD_W-1:0] ibWdata,
  output logic              ibWe,
  output logic              ibRe,
  input  logic [WORD_W-1:0] ibRdata,
  output logic [1:0]        streamSel,
  output logic [WORD_W-1:0] streamWdata,
  output logic              streamWe,
  output logic              streamRe,
  input  logic [WORD_W-1:0] streamRdata
);
  accessStrobesT strobes;
  logic          modeWide;

  hrb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .weN(weN),
    .hostAddr(hostAddr), .strobes(strobes)
  );

  hrb_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .ibAddr(ibAddr), .ibWdata(ibWdata), .ibWe(ibWe),
    .ibRe(ibRe), .ibRdata(ibRdata), .streamSel(streamSel),
    .streamWdata(streamWdata), .streamWe(streamWe), .streamRe(streamRe),
    .streamRdata(streamRdata), .modeWide(modeWide)
  );
endmodule

// File: rtl/hrb_checker.sv
module hrb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ibWe,
  input logic        ibRe,
  input logic        streamWe,
  input logic        streamRe,
  input logic [31:0] hostRdata,
  input logic        modeWide
);
  // R6
  ib_write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) ibWe |=> !ibWe);
  // R6
  ib_no_collide_chk: assert property (@(posedge clk) disable iff (!rstN) ibWe |-> !ibRe);
  // R7
  ib_read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) ibRe |=> !ibRe);
  // R9
  stream_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamWe || streamRe) |=> !(streamWe || streamRe));
  // R9
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({streamWe, streamRe, ibWe, ibRe}));
  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(hostRdata) && !modeWide) |-> hostRdata[31:16] == 16'h0);
endmodule

bind halfword_reg_bridge hrb_checker chk_i (
  .clk(clk), .rstN(rstN), .ibWe(ibWe), .ibRe(ibRe), .streamWe(streamWe),
  .streamRe(streamRe), .hostRdata(hostRdata), .modeWide(modeWide)
);

// File: tb/halfword_reg_bridge_tb.sv
module halfword_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, weN = 1'b1;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata, ibAddr, ibWdata, ibRdata, streamWdata;
  logic        ibWe, ibRe, streamWe, streamRe;
  logic [1:0]  streamSel;
  logic [31:0] streamRdata = 32'hCAFE_F00D;

  int errors = 0, checks = 0;
  bit busy = 1'b1, done = 1'b0;

  // behavioural reference state
  int unsigned mGen [16];
  int unsigned mStage = 0, mIaddr = 0;
  bit          mWide = 1'b0;
  int unsigned mMem [int unsigned];
  int unsigned expRdata = 0;

  int ibWeCnt = 0, ibReCnt = 0, stWeCnt = 0, stReCnt = 0;
  logic [31:0] lastIbAddr, lastIbData, lastStData;
  logic [1:0]  lastStSel;

  halfword_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .weN(weN),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .ibAddr(ibAddr), .ibWdata(ibWdata), .ibWe(ibWe), .ibRe(ibRe),
    .ibRdata(ibRdata), .streamSel(streamSel), .streamWdata(streamWdata),
    .streamWe(streamWe), .streamRe(streamRe), .streamRdata(streamRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // internal bus slave: one-cycle read latency
  always @(posedge clk) begin
    if (ibWe) mMem[ibAddr] = ibWdata;
    if (ibRe) ibRdata <= mMem.exists(ibAddr) ? mMem[ibAddr] : 32'h0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ibWe) begin ibWeCnt++; lastIbAddr = ibAddr; lastIbData = ibWdata; end
    if (ibRe) ibReCnt++;
    if (streamWe) begin stWeCnt++; lastStSel = streamSel; lastStData = streamWdata; end
    if (streamRe) begin stReCnt++; lastStSel = streamSel; end
    if (!busy && rstN && !done) chk("R1-model read data", hostRdata, expRdata);
  end

  function automatic bit isGen(int a);
    return !(a <= 3 || a == 10 || a == 11 || a == 12);
  endfunction

  task automatic strobe(input logic [3:0] a, input logic [31:0] d, input bit wr);
    busy = 1'b1;
    @(negedge clk);
    hostAddr = a; hostWdata = d; csN = 1'b0;
    if (wr) weN = 1'b0; else rdN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1; weN = 1'b1; rdN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [31:0] d);
    int unsigned full;
    full = mWide ? d : {mStage[15:0], d[15:0]};
    strobe(a, d, 1'b1);
    if (isGen(a)) begin
      mGen[a] = {16'h0, d[15:0]};
      if (a == 4'h8) mWide = d[0];
    end else if (a == 4'hA) mStage = {16'h0, d[15:0]};
    else if (a == 4'hB) mIaddr = full;
    busy = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [31:0] r);
    int unsigned v;
    strobe(a, 32'h0, 1'b0);
    v = 0;
    if (a <= 2) v = mWide ? streamRdata : {16'h0, streamRdata[15:0]};
    else if (isGen(a)) v = mGen[a];
    else if (a == 4'hA) v = mStage;
    else if (a == 4'hB || a == 4'hC) begin
      v = (a == 4'hB) ? mIaddr : (mMem.exists(mIaddr) ? mMem[mIaddr] : 0);
      if (!mWide) begin mStage = {16'h0, v[15:0]}; v = {16'h0, v[31:16]}; end
    end
    expRdata = v;
    r = hostRdata;
    busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int c0;
    for (int i = 0; i < 16; i++) mGen[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", hostRdata, 32'h0);
    chk("R1 reset strobes", {28'h0, ibWe, ibRe, streamWe, streamRe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    hostRead(4'hA, r); chk("R1 stage after reset", r, 32'h0);

    hostWrite(4'h4, 32'hABCD_1234);
    hostRead(4'h4, r); chk("R2 narrow 16-bit reg", r, 32'h0000_1234);

    hostWrite(4'hA, 32'h0000_5A5A);
    hostRead(4'hA, r); chk("R5 stage readback", r, 32'h0000_5A5A);

    hostWrite(4'hA, 32'h0000_1234);
    hostWrite(4'hB, 32'h0000_5678);
    hostRead(4'hB, r); chk("R4 upper half first", r, 32'h0000_1234);
    hostRead(4'hA, r); chk("R3 R4 lower parked", r, 32'h0000_5678);

    hostWrite(4'hA, 32'h0000_DEAD);
    c0 = ibWeCnt;
    hostWrite(4'hC, 32'h0000_BEEF);
    chk("R6 R12 one ib write", ibWeCnt - c0, 1);
    chk("R6 ib address", lastIbAddr, 32'h1234_5678);
    chk("R3 R6 ib data", lastIbData, 32'hDEAD_BEEF);

    c0 = ibReCnt;
    hostRead(4'hC, r);
    chk("R7 one ib read", ibReCnt - c0, 1);
    chk("R7 R4 idata upper", r, 32'h0000_DEAD);
    hostRead(4'hA, r); chk("R7 idata lower parked", r, 32'h0000_BEEF);

    hostWrite(4'h3, 32'hFFFF_FFFF);
    hostRead(4'h3, r); chk("R8 reserved reads zero", r, 32'h0);
    hostRead(4'hA, r); chk("R8 stage untouched", r, 32'h0000_BEEF);
    hostRead(4'h4, r); chk("R8 reg untouched", r, 32'h0000_1234);

    c0 = stWeCnt;
    hostWrite(4'h1, 32'h7777_8888);
    chk("R9 one stream write", stWeCnt - c0, 1);
    chk("R9 stream sel", {30'h0, lastStSel}, 32'h1);
    chk("R9 narrow stream data", lastStData, 32'h0000_8888);
    c0 = stReCnt;
    hostRead(4'h2, r);
    chk("R9 narrow stream read", r, 32'h0000_F00D);
    chk("R9 one stream pop", stReCnt - c0, 1);
    chk("R9 pop sel", {30'h0, lastStSel}, 32'h2);
    hostRead(4'hA, r); chk("R9 stage not used", r, 32'h0000_BEEF);

    hostWrite(4'h8, 32'h0000_0001);
    hostWrite(4'hB, 32'h0000_0100);
    hostWrite(4'hC, 32'h1122_3344);
    chk("R11 R10 wide ib address", lastIbAddr, 32'h0000_0100);
    chk("R10 wide ib data", lastIbData, 32'h1122_3344);
    hostRead(4'hC, r); chk("R10 wide idata read", r, 32'h1122_3344);
    hostRead(4'hB, r); chk("R10 wide iaddr read", r, 32'h0000_0100);
    hostRead(4'hA, r); chk("R10 stage untouched", r, 32'h0000_BEEF);

    hostWrite(4'h5, 32'hFFFF_4321);
    hostRead(4'h5, r); chk("R2 wide 16-bit reg", r, 32'h0000_4321);

    hostWrite(4'h0, 32'h9999_8888);
    chk("R9 wide stream data", lastStData, 32'h9999_8888);
    chk("R9 stream sel 0", {30'h0, lastStSel}, 32'h0);
    hostRead(4'h0, r); chk("R9 wide stream read", r, 32'hCAFE_F00D);

    hostWrite(4'h8, 32'h0000_0000);
    hostRead(4'hB, r); chk("R11 back to narrow upper", r, 32'h0000_0000);
    hostRead(4'hA, r); chk("R11 narrow parked lower", r, 32'h0000_0100);

    // R12: read and write strobes together, write wins
    busy = 1'b1;
    @(negedge clk);
    hostAddr = 4'h6; hostWdata = 32'h0000_00A5; csN = 1'b0; weN = 1'b0; rdN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1; weN = 1'b1; rdN = 1'b1;
    repeat (4) @(negedge clk);
    mGen[6] = 32'hA5;
    busy = 1'b0;
    chk("R12 write wins, rdata kept", hostRdata, expRdata);
    hostRead(4'h6, r); chk("R12 write took effect", r, 32'h0000_00A5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule